// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block drives a three-wire serial EEPROM (select, serial clock, serial data toward the memory, serial data from the memory) and fetches 16-bit words from it. Once reset is released it runs a sizing pass on its own. That pass finds out whether the memory takes 6-bit or 8-bit word addresses. After the pass it serves read requests through a handshake: a word address goes in, and a 16-bit word comes back with a single-cycle completion pulse.

Every serial transfer is paced by a down-counter that counts system clock cycles, so the clock half-period and the select gaps are parameters. The memory signals that it has taken the address by returning a zero bit. If that zero does not appear, the block closes the transfer and starts it again, up to a retry limit. When the limit is used up it finishes the transfer anyway and sets a sticky error flag.

Top module: `mwr_eeprom_rd`

## Requirements
- R1: A read sends the opcode bits 1,1,0 and then the word address, each most significant bit first, on `ee_di`. The address is the low 6 bits of `req_addr` when the detected width is 6, and all 8 bits when it is 8.
- R2: Each outgoing bit takes three steps of `HALF_CYC` cycles each: data set with the clock low, clock high, clock low. Of `ee_cs`, `ee_sk` and `ee_di`, at most one changes per cycle. `ee_di` holds its value while the clock is high and in the cycle the clock falls. `ee_sk` is high only while `ee_cs` is high.
- R3: The sizing pass sends the opcode and then zero address bits, sampling `ee_do` after each one. It stops at the first 0 and takes the count of address bits as the width. Against a memory with 8 address bits, `addr_width` reads 8.
- R4: A sizing count other than 6 or 8, including no 0 seen within 12 address bits, gives `addr_width` = 6.
- R5: The sizing pass clocks a 16-bit word and discards it in one select period. `rsp_done` does not pulse during sizing, and `req_ready` stays low until sizing ends.
- R6: After the address, the block samples `ee_do` with the clock low. A 1 there ends the access and restarts it. At most 10 restarts are made. A read that succeeds after 10 failed attempts uses 11 select periods and leaves `err_retry` low.
- R7: On an 11th failure the block clocks the data word in anyway, pulses `rsp_done`, and sets `err_retry`. The flag stays set until reset.
- R8: The 16 data bits are taken MSB first, each sampled while `ee_sk` is high, and returned on `rsp_data`.
- R9: `ee_cs` rises `EN_CYC` cycles after the select-low step and stays high for `EN_CYC + HALF_CYC` cycles before the first clock rise. Between two select periods it is low for at least `DONE_CYC + EN_CYC` cycles.
- R10: `req_ready` is high only when idle and sized. A request is taken when `req_valid` and `req_ready` are both high. `rsp_done` lasts one cycle and `rsp_data` holds its value afterwards. During reset all outputs except `addr_width` are 0.
- R11: Every high phase of `ee_sk` lasts exactly `HALF_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | WIDE_AW | Word address of the request |
| req_ready | output | 1 | Idle and sized; a request is accepted |
| rsp_done | output | 1 | One-cycle pulse when the word is ready |
| rsp_data | output | WORD_W | Word read, held until the next completion |
| err_retry | output | 1 | Sticky: a read used up its retries |
| addr_width | output | 4 | Detected address width, 6 or 8 |
| ee_cs | output | 1 | Memory select |
| ee_sk | output | 1 | Serial clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
The line assertions assume that nothing but the block's own sequencer moves `ee_cs`, `ee_sk` and `ee_di`. The completion and width assertions assume that `req_valid` matters only while `req_ready` is high. The bench drives the request pins only on falling clock edges, and it holds `req_valid` for exactly one cycle in which the block is ready. The memory model changes `ee_do` only on a rising `ee_sk` or a change of select, which keeps that input stable for several system cycles before each sample. This is why `HALF_CYC` must exceed the synchronizer depth.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_CSLO, S_CSHI, S_BSET, S_BHI, S_BLO,
      S_CONF, S_DHI, S_DLO, S_END
   } mwr_state_t;

   localparam int          MWR_OP_W    = 3;
   localparam logic [2:0]  MWR_READ_OP = 3'b110;
endpackage

// File: rtl/mwr_insync.sv
module mwr_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 1) begin : g_single
         logic ff;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) ff <= 1'b1;
            else        ff <= d;
         assign q = ff;
      end else begin : g_chain
         logic [STAGES-1:0] ff;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) ff <= '1;
            else        ff <= {ff[STAGES-2:0], d};
         assign q = ff[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mwr_dly.sv
module mwr_dly #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] val,
   output logic         expire
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;

   assign expire = (cnt == '0);
endmodule

// File: rtl/mwr_eeprom_rd.sv
module mwr_eeprom_rd
   import mwr_pkg::*;
#(
   parameter int WORD_W      = 16,
   parameter int NARROW_AW   = 6,
   parameter int WIDE_AW     = 8,
   parameter int PROBE_LIMIT = 12,
   parameter int MAX_RETRY   = 10,
   parameter int HALF_CYC    = 125,
   parameter int EN_CYC      = 250,
   parameter int DONE_CYC    = 250,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [WIDE_AW-1:0] req_addr,
   output logic               req_ready,
   output logic               rsp_done,
   output logic [WORD_W-1:0]  rsp_data,
   output logic               err_retry,
   output logic [3:0]         addr_width,
   output logic               ee_cs,
   output logic               ee_sk,
   output logic               ee_di,
   input  logic               ee_do
);
   localparam int SR_W    = MWR_OP_W + PROBE_LIMIT;
   localparam int SENT_W  = $clog2(SR_W + 1);
   localparam int DC_W    = $clog2(WORD_W);
   localparam int RT_W    = $clog2(MAX_RETRY + 1);
   localparam int DLY_MAX = (HALF_CYC > EN_CYC) ?
                            ((HALF_CYC > DONE_CYC) ? HALF_CYC : DONE_CYC) :
                            ((EN_CYC > DONE_CYC) ? EN_CYC : DONE_CYC);
   localparam int DLY_W   = $clog2(DLY_MAX + 1);

   generate
      if (SYNC_STAGES < 1)                   begin : g_bad_sync  $error("SYNC_STAGES must be at least 1"); end
      if (HALF_CYC < SYNC_STAGES + 2)        begin : g_bad_half  $error("HALF_CYC too short for the input synchronizer"); end
      if (EN_CYC < 1 || DONE_CYC < 1)        begin : g_bad_gap   $error("select delays must be at least one cycle"); end
      if (NARROW_AW >= WIDE_AW)              begin : g_bad_aw    $error("NARROW_AW must be below WIDE_AW"); end
      if (WIDE_AW > PROBE_LIMIT || PROBE_LIMIT > 15) begin : g_bad_probe $error("PROBE_LIMIT out of range"); end
      if (MAX_RETRY < 1)                     begin : g_bad_retry $error("MAX_RETRY must be at least 1"); end
   endgenerate

   mwr_state_t               st, st_n;
   logic                     sizing, sized, again;
   logic [SR_W-1:0]          cmd_sr;
   logic [SENT_W-1:0]        sent, sent_n, probe;
   logic [DC_W-1:0]          dcnt;
   logic [RT_W-1:0]          retries;
   logic [WORD_W-1:0]        dsr;
   logic [WIDE_AW-1:0]       addr_q;
   logic [3:0]               awidth, det_w;
   logic                     dsamp, expire, tmr_load, b_last, do_retry, d_last, wide;
   logic [DLY_W-1:0]         tmr_val;

   function automatic logic [SR_W-1:0] cmd_word(input logic w8, input logic [WIDE_AW-1:0] a);
      logic [SR_W-1:0] v;
      v = '0;
      v[SR_W-1 -: MWR_OP_W] = MWR_READ_OP;
      if (w8) v[SR_W-MWR_OP_W-1 -: WIDE_AW]   = a;
      else    v[SR_W-MWR_OP_W-1 -: NARROW_AW] = a[NARROW_AW-1:0];
      return v;
   endfunction

   function automatic logic [DLY_W-1:0] dly_m1(input mwr_state_t s);
      case (s)
         S_CSLO, S_CSHI: return DLY_W'(EN_CYC - 1);
         S_END:          return DLY_W'(DONE_CYC - 1);
         S_IDLE:         return '0;
         default:        return DLY_W'(HALF_CYC - 1);
      endcase
   endfunction

   mwr_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ee_do), .q(dsamp));

   mwr_dly #(.W(DLY_W)) u_dly (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expire(expire));

   assign wide     = (awidth == 4'(WIDE_AW));
   assign sent_n   = sent + 1'b1;
   assign probe    = sent_n - SENT_W'(MWR_OP_W);
   assign det_w    = (probe == SENT_W'(NARROW_AW) || probe == SENT_W'(WIDE_AW)) ?
                     4'(probe) : 4'(NARROW_AW);
   assign b_last   = sizing ? ((sent_n > SENT_W'(MWR_OP_W)) && (!dsamp || sent_n == SENT_W'(SR_W)))
                            : (sent_n == SENT_W'(MWR_OP_W) + SENT_W'(awidth));
   assign do_retry = !sizing && dsamp && (retries < RT_W'(MAX_RETRY));
   assign d_last   = (dcnt == DC_W'(WORD_W - 1));

   always_comb begin
      st_n = st;
      case (st)
         S_IDLE: if (!sized || req_valid) st_n = S_CSLO;
         S_CSLO: if (expire) st_n = S_CSHI;
         S_CSHI: if (expire) st_n = S_BSET;
         S_BSET: if (expire) st_n = S_BHI;
         S_BHI:  if (expire) st_n = S_BLO;
         S_BLO:  if (expire) st_n = b_last ? S_CONF : S_BSET;
         S_CONF: if (expire) st_n = do_retry ? S_END : S_DHI;
         S_DHI:  if (expire) st_n = S_DLO;
         S_DLO:  if (expire) st_n = d_last ? S_END : S_DHI;
         S_END:  if (expire) st_n = again ? S_CSLO : S_IDLE;
         default:            st_n = S_IDLE;
      endcase
   end

   assign tmr_load = (st_n != st);
   assign tmr_val  = dly_m1(st_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         sizing    <= 1'b0;
         sized     <= 1'b0;
         again     <= 1'b0;
         cmd_sr    <= '0;
         sent      <= '0;
         dcnt      <= '0;
         retries   <= '0;
         dsr       <= '0;
         addr_q    <= '0;
         awidth    <= 4'(NARROW_AW);
         rsp_done  <= 1'b0;
         rsp_data  <= '0;
         err_retry <= 1'b0;
      end else begin
         st       <= st_n;
         rsp_done <= 1'b0;
         case (st)
            S_IDLE: if (st_n == S_CSLO) begin
               if (!sized) begin
                  sizing <= 1'b1;
                  cmd_sr <= cmd_word(1'b0, '0);
               end else begin
                  addr_q  <= req_addr;
                  cmd_sr  <= cmd_word(wide, req_addr);
                  retries <= '0;
               end
            end
            S_CSHI: if (expire) sent <= '0;
            S_BLO: if (expire) begin
               sent   <= sent_n;
               cmd_sr <= cmd_sr << 1;
               if (sizing && b_last) awidth <= det_w;
            end
            S_CONF: if (expire) begin
               dcnt  <= '0;
               again <= do_retry;
               if (do_retry) retries <= retries + 1'b1;
               if (!sizing && dsamp && !do_retry) err_retry <= 1'b1;
            end
            S_DHI: if (expire) dsr  <= {dsr[WORD_W-2:0], dsamp};
            S_DLO: if (expire) dcnt <= dcnt + 1'b1;
            S_END: if (expire) begin
               if (again) begin
                  again  <= 1'b0;
                  cmd_sr <= cmd_word(wide, addr_q);
               end else if (sizing) begin
                  sizing <= 1'b0;
                  sized  <= 1'b1;
               end else begin
                  rsp_done <= 1'b1;
                  rsp_data <= dsr;
               end
            end
            default: ;
         endcase
      end
   end

   assign req_ready  = sized && (st == S_IDLE);
   assign addr_width = awidth;
   assign ee_cs      = !(st inside {S_IDLE, S_CSLO, S_END});
   assign ee_sk      = (st == S_BHI) || (st == S_DHI);
   assign ee_di      = (st inside {S_BSET, S_BHI, S_BLO}) && cmd_sr[SR_W-1];

   // Serial line discipline (R2)
   p_sk_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n) ee_sk |-> ee_cs);
   p_one_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!$stable(ee_cs), !$stable(ee_sk), !$stable(ee_di)}) <= 1);
   p_di_hold_r2:  assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sk || $past(ee_sk)) |-> $stable(ee_di));
   // Width status is always a legal value once requests are open (R4)
   p_width_ok_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (addr_width == 4'(NARROW_AW) || addr_width == 4'(WIDE_AW)));
   // No completion while sizing (R5)
   p_quiet_size_r5: assert property (@(posedge clk) disable iff (!rst_n) sizing |-> !rsp_done);
   // Retry count bounded (R6)
   p_retry_cap_r6: assert property (@(posedge clk) disable iff (!rst_n) retries <= RT_W'(MAX_RETRY));
   // Error flag never clears (R7)
   p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n) err_retry |=> err_retry);
   // Handshake (R10)
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) rsp_done |=> !rsp_done);
   p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !ee_cs);
endmodule

// File: tb/mwr_eeprom_rd_bench.sv
module mwr_eeprom_rd_bench;
   localparam int HALF = 4;
   localparam int EN   = 6;
   localparam int DONE = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_addr = '0;
   logic        req_ready, rsp_done, err_retry, ee_cs, ee_sk, ee_di;
   logic [15:0] rsp_data;
   logic [3:0]  addr_width;
   logic        m_do = 1'b1;

   int checks = 0, fails = 0, cyc = 0;

   always #2 clk = ~clk;

   mwr_eeprom_rd #(.HALF_CYC(HALF), .EN_CYC(EN), .DONE_CYC(DONE)) u_mwr_eeprom_rd (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_data(rsp_data),
      .err_retry(err_retry), .addr_width(addr_width),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(m_do));

   function automatic logic [15:0] mem(input int a);
      logic [7:0] b;
      b = 8'(a);
      return {b, ~b} ^ 16'h5A3C;
   endfunction

   // memory model
   int          m_abits = 8, m_fail = 0, m_cnt = 0, m_access = 0, m_addr = -1, m_op = -1;
   logic        m_bad = 1'b0;
   logic [31:0] m_sr = '0;
   logic [15:0] m_word = '0;

   always @(posedge ee_cs) begin
      m_cnt = 0; m_sr = '0; m_do = 1'b1;
      m_bad = (m_fail > 0);
      if (m_fail > 0) m_fail--;
      m_access++;
   end
   always @(negedge ee_cs) m_do = 1'b1;
   always @(posedge ee_sk) if (ee_cs) begin
      if (m_cnt < 3 + m_abits) begin
         m_sr = {m_sr[30:0], ee_di};
         m_cnt++;
         if (m_cnt == 3 + m_abits) begin
            m_addr = int'(m_sr & ((32'd1 << m_abits) - 1));
            m_op   = int'((m_sr >> m_abits) & 32'd7);
            m_word = mem(m_addr);
            if (!m_bad) m_do = 1'b0;
         end
      end else if (!m_bad) begin
         m_do   = m_word[15];
         m_word = {m_word[14:0], 1'b0};
      end
   end

   // line monitors
   int   dones = 0, hi = 0, sk_bad = 0, line_bad = 0, lead = 0, lead_bad = 0, gap = 0, gap_bad = 0;
   logic seen = 1'b0, had = 1'b0, pcs = 1'b0, psk = 1'b0, pdi = 1'b0;
   always @(negedge clk) begin
      if (!rst_n) begin
         had = 1'b0; gap = 0; hi = 0; seen = 1'b0; lead = 0;
      end else begin
         if (rsp_done) dones++;
         if (ee_sk) hi++;
         else begin
            if (hi != 0 && hi != HALF) sk_bad++;
            hi = 0;
         end
         if (int'(ee_cs != pcs) + int'(ee_sk != psk) + int'(ee_di != pdi) > 1) line_bad++;
         if ((ee_sk || psk) && ee_di != pdi) line_bad++;
         if (ee_sk && !ee_cs) line_bad++;
         if (ee_cs) begin
            if (gap > 0) begin
               if (had && gap < DONE + EN) gap_bad++;
               had = 1'b1; gap = 0;
            end
            if (!seen) begin
               if (!ee_sk) lead++;
               else begin
                  seen = 1'b1;
                  if (lead != EN + HALF) lead_bad++;
               end
            end
         end else begin
            gap++; seen = 1'b0; lead = 0;
         end
      end
      pcs = ee_cs; psk = ee_sk; pdi = ee_di;
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input int abits);
      m_abits = abits; m_fail = 0;
      rst_n = 1'b0; req_valid = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_ready();
      while (!req_ready) @(negedge clk);
   endtask

   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!req_ready && !rsp_done && !err_retry && !ee_cs && !ee_sk && !ee_di,
          "R10 reset outputs", {req_ready, rsp_done, err_retry, ee_cs, ee_sk, ee_di}, 0);
   endtask

   task automatic t_sizing(input int abits, input int exp_w, input string tag);
      int d0;
      do_reset(abits);
      d0 = dones;
      m_access = 0;
      @(negedge clk);
      chk(!req_ready, "R5 ready held during sizing", req_ready, 0);
      wait_ready();
      chk(addr_width == 4'(exp_w), tag, addr_width, exp_w);
      chk(dones == d0 && m_access == 1, "R5 one silent sizing access", m_access * 16 + dones - d0, 16);
   endtask

   task automatic t_read(input int addr, input int nfail, input int exp_acc,
                         input logic exp_err, input logic [15:0] exp_data, input int mask);
      int a0;
      logic [15:0] held;
      wait_ready();
      m_fail = nfail;
      a0 = m_access;
      req_valid = 1'b1; req_addr = 8'(addr);
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R10 ready drops on accept", req_ready, 0);
      while (!rsp_done) @(negedge clk);
      chk(rsp_data == exp_data, "R8 word value", rsp_data, exp_data);
      chk(m_op == 6, "R1 opcode", m_op, 6);
      chk(m_addr == (addr & mask), "R1 address", m_addr, addr & mask);
      chk(m_access - a0 == exp_acc, "R6 select periods", m_access - a0, exp_acc);
      chk(err_retry == exp_err, "R7 error flag", err_retry, exp_err);
      held = rsp_data;
      @(negedge clk);
      chk(!rsp_done && rsp_data == held, "R10 one-cycle done, data held", {rsp_done, rsp_data}, held);
   endtask

   task automatic t_lines();
      chk(line_bad == 0, "R2 line steps", line_bad, 0);
      chk(sk_bad == 0, "R11 clock high width", sk_bad, 0);
      chk(lead_bad == 0, "R9 select lead", lead_bad, 0);
      chk(gap_bad == 0, "R9 select gap", gap_bad, 0);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         finish_run();
      end
   end

   initial begin
      t_reset_state();
      t_sizing(8, 8, "R3 eight-bit detect");
      t_read(8'h00, 0, 1, 1'b0, mem(8'h00), 8'hFF);
      t_read(8'hA5, 0, 1, 1'b0, mem(8'hA5), 8'hFF);
      t_read(8'hFF, 0, 1, 1'b0, mem(8'hFF), 8'hFF);
      t_read(8'h3C, 3, 4, 1'b0, mem(8'h3C), 8'hFF);       // R6 a few retries
      t_read(8'h81, 10, 11, 1'b0, mem(8'h81), 8'hFF);     // R6 limit reached, success
      t_read(8'h42, 11, 11, 1'b1, 16'hFFFF, 8'hFF);       // R7 exhausted
      t_read(8'h17, 0, 1, 1'b1, mem(8'h17), 8'hFF);       // R7 flag stays set
      t_lines();
      t_sizing(6, 6, "R3 six-bit detect");
      t_read(8'hFF, 0, 1, 1'b0, mem(8'h3F), 8'h3F);       // R1 high bits dropped
      t_read(8'h15, 0, 1, 1'b0, mem(8'h15), 8'h3F);
      t_sizing(7, 6, "R4 odd width falls back");
      t_sizing(13, 6, "R4 no dummy bit falls back");
      t_lines();
      finish_run();
   end
endmodule